// File: doc/BRIEF.md
# Periodic Down-Count Tick Timer

A 24-bit periodic tick timer that sits behind a small 32-bit register bus. Software loads a reload value, picks a count rate and starts the counter. The counter counts down to zero, reloads and starts again. Each wrap from one to zero sets a sticky count flag and can raise an interrupt pulse. The count rate is either every core clock cycle or a reference tick. The reference tick is a single-cycle enable pulse that is already synchronous to the core clock.

The block also has a read-only calibration word. It is fixed when the design is elaborated, from two parameters: whether a reference tick exists, and its frequency. The word gives the number of reference ticks in 10 ms, less one. It has a bit that marks an inexact count and a bit that marks a missing reference. With no reference tick fitted, the source-select bit is pinned to the core clock.

Top module: `tick_timer`

## Requirements
- R1: The control word at offset 0x0 holds enable in bit 0, interrupt enable in bit 1, source select in bit 2 (1 = every core clock, 0 = reference tick pulses) and the count flag in bit 16. A write changes only bits [2:0]. All other bits read 0.
- R2: After reset, control, reload and current value all read 0 and the interrupt output is low. The one exception is source select, which reads 1 when no reference tick exists.
- R3: While enabled, each selected tick decrements a non-zero counter. A tick that finds the counter at 0 loads the reload value. A reload of 0 leaves the counter idle at 0. While disabled, the counter does not move.
- R4: A tick that takes the counter from 1 to 0 sets the count flag. If interrupt enable is set, it also drives the interrupt output high for exactly the one cycle after that clock edge. If interrupt enable is clear, the interrupt stays low.
- R5: A read of the control word returns the flag as it stood before the read and then clears it. If a wrap occurs in the same cycle as the read, the flag is left set.
- R6: Any write to the current-value offset sets the counter and the count flag to 0, whatever the data. This wins over a tick in the same cycle and never produces an interrupt.
- R7: Source select changes the count rate from the next clock edge on, with no need to toggle enable. Reference pulses are counted only while bit 2 is 0.
- R8: When no reference tick exists, source select reads 1 at all times, whatever value was written.
- R9: With a reference tick fitted, the calibration word at 0xC holds (REF_HZ/100 - 1) truncated to 24 bits in bits [23:0]. Bit 30 is set when that count is not exact, that is, when REF_HZ is not a multiple of 100 or the count was truncated. Bit 31 is 0.
- R10: With no reference tick, the calibration word reads 0x8000_0000.
- R11: Offset 0x4 is the reload value. Only its low 24 bits are stored, and its upper bits read 0. Offset 0x8 is the current value. Any other offset, including an offset that is not word aligned, reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | Reference tick enable, one core-clock cycle wide |
| bus_req | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read request |
| irq | output | 1 | Interrupt pulse on wrap |

## Verification
Two of the block's functions act on the count flag and can land in the same cycle: the flag clear caused by a control read, and the flag set caused by a wrap. The bench issues the control read in the same cycle as the reference pulse that takes the counter from 1 to 0. It expects the read to return the flag clear and the interrupt to pulse. A later read must then see the flag still set. In the same way, a current-value write is driven in the same cycle as a tick that would otherwise wrap. The bench judges by the later readback that the clear won and that no interrupt was raised.

// File: rtl/tick_timer_pkg.sv
// Shared constants, slot encoding and the calibration function of the tick timer.
// Assumes a 32-bit register word and a 24-bit calibration count field.
package tick_timer_pkg;

    localparam int REG_W         = 32;
    localparam int TENMS_W       = 24;
    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_INT_BIT  = 1;
    localparam int CTRL_SRC_BIT  = 2;
    localparam int CTRL_FLAG_BIT = 16;
    localparam int CAL_SKEW_BIT  = 30;
    localparam int CAL_NOREF_BIT = 31;

    typedef enum logic [1:0] {
        SLOT_CTRL   = 2'd0,
        SLOT_RELOAD = 2'd1,
        SLOT_CUR    = 2'd2,
        SLOT_CAL    = 2'd3
    } slot_e;

    // Build the calibration word from the reference-tick parameters.
    function automatic logic [REG_W-1:0] calib_word(input bit has_ref, input longint ref_hz);
        logic [REG_W-1:0] w;
        longint           ticks;
        longint           field_max;
        w         = '0;
        field_max = (longint'(1) << TENMS_W) - 1;
        if (!has_ref) begin
            w[CAL_NOREF_BIT] = 1'b1;
        end else begin
            ticks               = ref_hz / 100;
            w[TENMS_W-1:0]      = TENMS_W'(ticks - 1);
            w[CAL_SKEW_BIT]     = ((ref_hz % 100) != 0) || ((ticks - 1) > field_max);
        end
        return w;
    endfunction

endpackage

// File: rtl/tick_timer_decode.sv
// Bus decode and read-data mux of the tick timer.
// Produces one write strobe per writable slot and a read strobe for the control slot.
// Assumes ADDR_W >= 4. Reads are combinational; a misaligned or out-of-range offset reads 0.
module tick_timer_decode
    import tick_timer_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int CNT_W   = 24,
    parameter bit HAS_REF = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              ctrl_en,
    input  logic              ctrl_int,
    input  logic              ctrl_src,
    input  logic              flag,
    input  logic [CNT_W-1:0]  reload,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [REG_W-1:0]  calib,
    output logic              wr_ctrl,
    output logic              wr_reload,
    output logic              wr_cur,
    output logic              rd_ctrl,
    output logic [REG_W-1:0]  rdata
);

    logic  hit;
    slot_e slot;

    // Offset is a mapped word when aligned and inside the four-slot window.
    assign hit  = (bus_addr[1:0] == 2'b00) && ((bus_addr >> 4) == '0);
    assign slot = slot_e'(bus_addr[3:2]);

    // Per-slot access strobes.
    assign wr_ctrl   = bus_req &&  bus_we && hit && (slot == SLOT_CTRL);
    assign wr_reload = bus_req &&  bus_we && hit && (slot == SLOT_RELOAD);
    assign wr_cur    = bus_req &&  bus_we && hit && (slot == SLOT_CUR);
    assign rd_ctrl   = bus_req && !bus_we && hit && (slot == SLOT_CTRL);

    // Read-data mux; zero outside a mapped read.
    always_comb begin
        rdata = '0;
        if (bus_req && !bus_we && hit) begin
            unique case (slot)
                SLOT_CTRL: begin
                    rdata[CTRL_EN_BIT]   = ctrl_en;
                    rdata[CTRL_INT_BIT]  = ctrl_int;
                    rdata[CTRL_SRC_BIT]  = ctrl_src;
                    rdata[CTRL_FLAG_BIT] = flag;
                end
                SLOT_RELOAD: rdata[CNT_W-1:0] = reload;
                SLOT_CUR:    rdata[CNT_W-1:0] = cnt;
                SLOT_CAL:    rdata = calib;
                default:     rdata = '0;
            endcase
        end
    end

    // R11: offsets past the window read zero.
    p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && (bus_addr >= ADDR_W'(16))) |-> (rdata == '0));

    generate
        if (!HAS_REF) begin : g_noref_chk
            // R8: source select always reads as core clock without a reference.
            p_src_pinned_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_req && !bus_we && (bus_addr == '0)) |-> rdata[CTRL_SRC_BIT]);
        end
    endgenerate

endmodule

// File: rtl/tick_timer_ctrl.sv
// Control bits and reload value of the tick timer.
// Only bits [2:0] of a control write are kept; the source bit is pinned high when no
// reference tick exists.
module tick_timer_ctrl #(
    parameter int CNT_W   = 24,
    parameter bit HAS_REF = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctrl,
    input  logic             wr_reload,
    input  logic             wd_en,
    input  logic             wd_int,
    input  logic             wd_src,
    input  logic [CNT_W-1:0] wd_reload,
    output logic             en_o,
    output logic             int_o,
    output logic             src_o,
    output logic [CNT_W-1:0] reload_o
);

    localparam logic SRC_PIN = HAS_REF ? 1'b0 : 1'b1;

    // Hold control bits and reload; the source bit resets to its pinned value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o     <= 1'b0;
            int_o    <= 1'b0;
            src_o    <= SRC_PIN;
            reload_o <= '0;
        end else begin
            if (wr_ctrl) begin
                en_o  <= wd_en;
                int_o <= wd_int;
                src_o <= wd_src | SRC_PIN;
            end
            if (wr_reload) begin
                reload_o <= wd_reload;
            end
        end
    end

endmodule

// File: rtl/tick_timer_core.sv
// Count engine of the tick timer: down-counter, sticky count flag and interrupt pulse.
// Assumes ref_tick is a single-cycle enable pulse synchronous to clk.
// Priority: a current-value clear beats everything; a wrap beats a flag-clearing read.
module tick_timer_core #(
    parameter int CNT_W   = 24,
    parameter bit HAS_REF = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             en,
    input  logic             int_en,
    input  logic             src,
    input  logic [CNT_W-1:0] reload,
    input  logic             clr_cur,
    input  logic             rd_clr,
    output logic [CNT_W-1:0] cnt_o,
    output logic             flag_o,
    output logic             irq_o
);

    logic rate_tick;
    logic step;
    logic wrap;

    generate
        if (HAS_REF) begin : g_ref
            // Select the count rate: every cycle or reference pulses.
            assign rate_tick = src ? 1'b1 : ref_tick;
        end else begin : g_noref
            logic unused_ref;
            // No reference fitted: count on every core cycle.
            assign unused_ref = ref_tick ^ src;
            assign rate_tick  = 1'b1;
        end
    endgenerate

    assign step = en && rate_tick;
    assign wrap = step && (cnt_o == CNT_W'(1));

    // Counter: reload at zero, decrement otherwise; cleared by a current-value write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (clr_cur) begin
            cnt_o <= '0;
        end else if (step) begin
            cnt_o <= (cnt_o == '0) ? reload : cnt_o - CNT_W'(1);
        end
    end

    // Sticky flag: a read clears it, a wrap sets it and wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (clr_cur) begin
            flag_o <= 1'b0;
        end else begin
            if (rd_clr) flag_o <= 1'b0;
            if (wrap)   flag_o <= 1'b1;
        end
    end

    // Interrupt: a one-cycle pulse after a wrap with interrupts enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= wrap && int_en && !clr_cur;
        end
    end

    // R3: a disabled counter stays put unless cleared.
    p_hold_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr_cur) |=> $stable(cnt_o));

    // R4: an interrupt pulse only accompanies a fresh wrap.
    p_irq_at_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (cnt_o == '0) && flag_o);

    // R4: the pulse lasts a single cycle when no further wrap can follow at once.
    p_irq_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && (reload != CNT_W'(1))) |=> !irq_o);

    // R6: a current-value write leaves counter and flag at zero, with no interrupt.
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cur |=> (cnt_o == '0) && !flag_o && !irq_o);

endmodule

// File: rtl/tick_timer.sv
// Top of the periodic down-count tick timer: joins decode, control and count engine,
// and fixes the calibration word at elaboration from HAS_REF and REF_HZ.
// Assumes REF_HZ >= 100 when HAS_REF is set, and CNT_W <= 32.
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int CNT_W   = 24,
    parameter bit HAS_REF = 1'b1,
    parameter int REF_HZ  = 1_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);

    localparam logic [REG_W-1:0] CALIB = calib_word(HAS_REF, longint'(REF_HZ));

    logic             wr_ctrl, wr_reload, wr_cur, rd_ctrl;
    logic             en, int_en, src, flag;
    logic [CNT_W-1:0] reload, cnt;
    logic             unused_wdata;

    assign unused_wdata = ^bus_wdata;

    tick_timer_decode #(
        .ADDR_W  (ADDR_W),
        .CNT_W   (CNT_W),
        .HAS_REF (HAS_REF)
    ) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .ctrl_en   (en),
        .ctrl_int  (int_en),
        .ctrl_src  (src),
        .flag      (flag),
        .reload    (reload),
        .cnt       (cnt),
        .calib     (CALIB),
        .wr_ctrl   (wr_ctrl),
        .wr_reload (wr_reload),
        .wr_cur    (wr_cur),
        .rd_ctrl   (rd_ctrl),
        .rdata     (bus_rdata)
    );

    tick_timer_ctrl #(
        .CNT_W   (CNT_W),
        .HAS_REF (HAS_REF)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl   (wr_ctrl),
        .wr_reload (wr_reload),
        .wd_en     (bus_wdata[CTRL_EN_BIT]),
        .wd_int    (bus_wdata[CTRL_INT_BIT]),
        .wd_src    (bus_wdata[CTRL_SRC_BIT]),
        .wd_reload (bus_wdata[CNT_W-1:0]),
        .en_o      (en),
        .int_o     (int_en),
        .src_o     (src),
        .reload_o  (reload)
    );

    tick_timer_core #(
        .CNT_W   (CNT_W),
        .HAS_REF (HAS_REF)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .en       (en),
        .int_en   (int_en),
        .src      (src),
        .reload   (reload),
        .clr_cur  (wr_cur),
        .rd_clr   (rd_ctrl),
        .cnt_o    (cnt),
        .flag_o   (flag),
        .irq_o    (irq)
    );

endmodule

// File: tb/tick_timer_test.sv
// Scoreboard bench: bus tasks queue expected read data, a monitor compares it.
module tick_timer_test;

    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ref_tick = 1'b0;
    logic              bus_req = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       rdata_a, rdata_b;
    logic              irq_a, irq_b;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    bit          q_nr[$];
    logic [31:0] q_exp[$];
    string       q_tag[$];

    always #2.5 clk = ~clk;

    tick_timer #(.ADDR_W(ADDR_W), .CNT_W(24), .HAS_REF(1'b1), .REF_HZ(32768)) uut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .irq(irq_a));

    tick_timer #(.ADDR_W(ADDR_W), .CNT_W(24), .HAS_REF(1'b0), .REF_HZ(1_000_000)) uut_noref (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .irq(irq_b));

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus cycle; optionally a reference pulse in the same cycle.
    task automatic bus_op(input bit we, input logic [7:0] addr, input logic [31:0] data,
                          input bit tick, input bit nr, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_req   = 1'b1;
        bus_we    = we;
        bus_addr  = addr;
        bus_wdata = data;
        ref_tick  = tick;
        if (!we) begin
            q_nr.push_back(nr);
            q_exp.push_back(exp);
            q_tag.push_back(tag);
        end
        @(negedge clk);
        bus_req  = 1'b0;
        bus_we   = 1'b0;
        ref_tick = 1'b0;
    endtask

    task automatic wr(input logic [7:0] addr, input logic [31:0] data);
        bus_op(1'b1, addr, data, 1'b0, 1'b0, '0, "");
    endtask

    task automatic rd(input logic [7:0] addr, input logic [31:0] exp, input string tag);
        bus_op(1'b0, addr, '0, 1'b0, 1'b0, exp, tag);
    endtask

    task automatic rd_nr(input logic [7:0] addr, input logic [31:0] exp, input string tag);
        bus_op(1'b0, addr, '0, 1'b0, 1'b1, exp, tag);
    endtask

    task automatic pulse();
        @(negedge clk);
        ref_tick = 1'b1;
        @(negedge clk);
        ref_tick = 1'b0;
    endtask

    // Monitor: compare each read against the queued expectation.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (bus_req && !bus_we) begin
                if (q_exp.size() == 0) begin
                    total++;
                    bad++;
                    $display("FAIL scoreboard: actual=read expected=queued item");
                end else begin
                    logic [31:0] e;
                    bit          n;
                    string       t;
                    e = q_exp.pop_front();
                    n = q_nr.pop_front();
                    t = q_tag.pop_front();
                    chk(n ? rdata_b : rdata_a, e, t);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk({31'b0, irq_a}, 32'h0, "R2 irq low after reset");
        rd(8'h0, 32'h0, "R2 control after reset");
        rd_nr(8'h0, 32'h4, "R2 R8 no-ref control after reset");
        rd(8'h4, 32'h0, "R2 reload after reset");
        rd(8'h8, 32'h0, "R2 current after reset");
        rd(8'hC, 32'h4000_0146, "R9 calibration 32768 Hz");
        rd_nr(8'hC, 32'h8000_0000, "R10 calibration no-ref");
        rd(8'h10, 32'h0, "R11 offset 0x10");
        rd(8'h6, 32'h0, "R11 misaligned offset");
        wr(8'h4, 32'hFF00_0005);
        rd(8'h4, 32'h0000_0005, "R11 reload upper bits");
        wr(8'h0, 32'h0001_0008);
        rd(8'h0, 32'h0, "R1 only bits 2:0 writable");
        rd_nr(8'h0, 32'h4, "R8 source pinned after write");

        // Reference-driven counting with interrupt.
        wr(8'h4, 32'h3);
        wr(8'h0, 32'h3);
        rd(8'h0, 32'h3, "R1 control readback");
        pulse();
        rd(8'h8, 32'h3, "R3 load from zero");
        pulse();
        pulse();
        rd(8'h8, 32'h1, "R3 decrement");
        // Control read in the same cycle as the wrapping tick.
        bus_op(1'b0, 8'h0, '0, 1'b1, 1'b0, 32'h3, "R5 read returns pre-edge flag");
        #1;
        chk({31'b0, irq_a}, 32'h1, "R4 irq after wrap");
        @(negedge clk);
        #1;
        chk({31'b0, irq_a}, 32'h0, "R4 irq one cycle");
        rd(8'h8, 32'h0, "R4 counter at zero");
        rd(8'h0, 32'h0001_0003, "R5 set wins over read clear");
        rd(8'h0, 32'h3, "R5 flag cleared by read");
        pulse();
        rd(8'h8, 32'h3, "R3 reload after zero");
        pulse();
        pulse();
        // Current-value write together with a wrapping tick.
        bus_op(1'b1, 8'h8, 32'h0000_0ABC, 1'b1, 1'b0, '0, "");
        #1;
        chk({31'b0, irq_a}, 32'h0, "R6 no irq on clear");
        rd(8'h8, 32'h0, "R6 counter cleared");
        rd(8'h0, 32'h3, "R6 flag not set");
        repeat (4) pulse();
        wr(8'h8, 32'h0);
        rd(8'h0, 32'h3, "R6 write clears set flag");

        // Disabled counter ignores pulses.
        pulse();
        wr(8'h0, 32'h0);
        pulse();
        rd(8'h8, 32'h3, "R3 hold while disabled");

        // Wrap without interrupt enable.
        wr(8'h4, 32'h1);
        wr(8'h8, 32'h0);
        wr(8'h0, 32'h1);
        pulse();
        pulse();
        #1;
        chk({31'b0, irq_a}, 32'h0, "R4 no irq without enable");
        rd(8'h0, 32'h0001_0001, "R4 flag without interrupt");

        // Core-clock rate for two edges, then back to reference pulses.
        wr(8'h4, 32'd10);
        wr(8'h8, 32'h0);
        wr(8'h0, 32'h5);
        wr(8'h0, 32'h1);
        rd(8'h8, 32'd9, "R7 core clock rate");
        pulse();
        rd(8'h8, 32'd8, "R7 switch to reference");

        @(negedge clk);
        if (q_exp.size() != 0) begin
            total++;
            bad++;
            $display("FAIL scoreboard: actual=%0d expected=0 pending", q_exp.size());
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule